// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static memory. It accepts one read or write command per clock. The data phase of every command falls two enabled clock edges after the command. A controller can therefore mix reads and writes on consecutive cycles without leaving the shared data path idle. A write is sampled on the data edge. Read data is held on the output between the first and the second edge after the command, and the controller samples it on the second edge. Writes can be masked per 9-bit byte lane.

A burst counter inside the block turns one loaded address into four beats. A load command takes the address from the pins. An advance command produces the next beat in linear or interleaved order and reuses the type and lane mask of the burst. An active-low clock enable freezes the whole block. Three chip selects gate new loads. An asynchronous output enable removes the read drive at once. The pad tri-state sits outside the block and is driven from `drive_o`.

Top module: `zbt_sram`

## Requirements
- R1: A read accepted on enabled edge k sets `drive_o` high and puts the word on `rdata_o` from enabled edge k+1 until edge k+2. A write accepted on edge k takes `wdata_i` on enabled edge k+2.
- R2: Reads and writes can be issued on every cycle in any mix. A read issued one cycle after a write to the same address returns the newly written data.
- R3: While `cke_ni` is high, every input is ignored and all state holds. This covers the pipeline, the outputs, the burst counter and the array. The pipeline resumes from that state when `cke_ni` returns low.
- R4: A load (`ld_ni` low) starts no operation unless `cs0_ni`=0, `cs1_i`=1 and `cs2_ni`=0. Operations already in the pipeline still complete.
- R5: `drive_o` is low during the data cycle of a write and during the data cycle of a load that did not select the chip.
- R6: An advance (`ld_ni` high) steps a 2-bit beat count. With linear order, latched from `lin_i`=1 at the load, the low two address bits are start+n mod 4. The upper address bits stay fixed. Chip selects, `addr_i`, `wr_i`, `bwe_i` and `lin_i` are ignored on an advance.
- R7: With interleaved order (`lin_i`=0 at the load), the low two address bits are start XOR n.
- R8: `bwe_i[n]`=1 enables writing bits [9n+8:9n] of the 36-bit word. Lanes that are not enabled keep their old contents.
- R9: An advance repeats the read/write type and the lane mask of its burst. An advance after reset or after a deselected load is a no-op.
- R10: `oe_ni` high forces `drive_o` low and `rdata_o` to zero at once, with no effect on the pipeline.
- R11: After reset `drive_o` is low, `rdata_o` is zero and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| cs0_ni | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_ni | input | 1 | Chip select, active low |
| ld_ni | input | 1 | 0 loads a new address, 1 advances the burst |
| wr_i | input | 1 | 1 write, 0 read (on load) |
| bwe_i | input | 4 | Byte-lane write enables (on load) |
| lin_i | input | 1 | 1 linear, 0 interleaved burst order (on load) |
| addr_i | input | 8 | Word address (on load) |
| wdata_i | input | 36 | Write data, sampled two edges after the write |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 36 | Read data, zero when not driving |
| drive_o | output | 1 | Pad drive enable for read data |

## Verification
If a pipeline stage is misaligned, `drive_o` or the read word shows up one cycle early or late. The table loop sees this on the first read after a write. If the burst state is wrong, the address of the first advance beat is wrong. Because every address in a burst holds a distinct word, the wrong data appears on the very next data cycle. A clock enable that does not hold state, or a select that leaks through, shows up as drive during a data cycle that should be idle, or as a changed word on a later read of an address the frozen write must not touch.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;

  // low address bits of beat n for a burst starting at start
  function automatic logic [1:0] beat_lsb(input logic [1:0] start,
                                          input logic [1:0] n,
                                          input logic       lin);
    return lin ? (start + n) : (start ^ n);
  endfunction

endpackage

// File: rtl/zbt_burst_ctl.sv
module zbt_burst_ctl #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sel_i,
  input  logic              ld_ni,
  input  logic              wr_i,
  input  logic [LANES-1:0]  bwe_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              op_vld_o,
  output logic              op_wr_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [LANES-1:0]  op_be_o,
  output logic              act_o
);
  import zbt_sram_pkg::*;

  logic              act_q, wr_q, lin_q;
  logic [LANES-1:0]  be_q;
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q, cnt_nx;

  assign cnt_nx = cnt_q + 2'd1;
  assign act_o  = act_q;

  always_comb begin
    if (!ld_ni) begin
      op_vld_o  = sel_i;
      op_wr_o   = wr_i;
      op_addr_o = addr_i;
      op_be_o   = bwe_i;
    end else begin
      op_vld_o  = act_q;
      op_wr_o   = wr_q;
      op_addr_o = {base_q[ADDR_W-1:2], beat_lsb(base_q[1:0], cnt_nx, lin_q)};
      op_be_o   = be_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      lin_q  <= 1'b1;
      be_q   <= '0;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (!ld_ni) begin
        act_q  <= sel_i;
        wr_q   <= wr_i;
        lin_q  <= lin_i;
        be_q   <= bwe_i;
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (act_q) begin
        cnt_q  <= cnt_nx;
      end
    end
  end

endmodule

// File: rtl/zbt_mem_array.sv
module zbt_mem_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANES-1:0]  wbe_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rword_o
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem_q [DEPTH];
    logic              lane_we;
    assign lane_we = we_i && wbe_i[l];

    always_ff @(posedge clk_i) begin
      if (en_i && lane_we) mem_q[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    // bypass a write that commits on the same edge the read word is captured
    assign rword_o[l*LANE_W +: LANE_W] =
      (lane_we && (waddr_i == raddr_i)) ? wdata_i[l*LANE_W +: LANE_W]
                                        : mem_q[raddr_i];
  end

endmodule

// File: rtl/zbt_out_stage.sv
module zbt_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              oe_ni,
  output logic              drv_q_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  logic              drv_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_q  <= 1'b0;
      data_q <= '0;
    end else if (en_i) begin
      drv_q <= rd_i;
      if (rd_i) data_q <= word_i;
    end
  end

  assign drv_q_o = drv_q;
  assign drive_o = drv_q && !oe_ni;
  assign rdata_o = drive_o ? data_q : '0;

endmodule

// File: rtl/zbt_sram.sv
module zbt_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_ni,
  input  logic              cs0_ni,
  input  logic              cs1_i,
  input  logic              cs2_ni,
  input  logic              ld_ni,
  input  logic              wr_i,
  input  logic [LANES-1:0]  bwe_i,
  input  logic              lin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              oe_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);

  logic              en, sel_ok, burst_act;
  logic              op_vld, op_wr;
  logic [ADDR_W-1:0] op_addr;
  logic [LANES-1:0]  op_be;

  logic              s1_vld, s1_wr, s2_vld, s2_wr;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_be, s2_be;
  logic [DATA_W-1:0] rword;
  logic              drv_q;

  assign en     = !cke_ni;
  assign sel_ok = !cs0_ni && cs1_i && !cs2_ni;

  zbt_burst_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .sel_i    (sel_ok),
    .ld_ni    (ld_ni),
    .wr_i     (wr_i),
    .bwe_i    (bwe_i),
    .lin_i    (lin_i),
    .addr_i   (addr_i),
    .op_vld_o (op_vld),
    .op_wr_o  (op_wr),
    .op_addr_o(op_addr),
    .op_be_o  (op_be),
    .act_o    (burst_act)
  );

  // two command stages: s1 = address phase done, s2 = data phase next edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_wr   <= 1'b0;
      s1_addr <= '0;
      s1_be   <= '0;
      s2_vld  <= 1'b0;
      s2_wr   <= 1'b0;
      s2_addr <= '0;
      s2_be   <= '0;
    end else if (en) begin
      s1_vld  <= op_vld;
      s1_wr   <= op_wr;
      s1_addr <= op_addr;
      s1_be   <= op_be;
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
    end
  end

  zbt_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i  (clk_i),
    .en_i   (en),
    .we_i   (s2_vld && s2_wr),
    .waddr_i(s2_addr),
    .wbe_i  (s2_be),
    .wdata_i(wdata_i),
    .raddr_i(s1_addr),
    .rword_o(rword)
  );

  zbt_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .rd_i   (s1_vld && !s1_wr),
    .word_i (rword),
    .oe_ni  (oe_ni),
    .drv_q_o(drv_q),
    .rdata_o(rdata_o),
    .drive_o(drive_o)
  );

endmodule

// File: rtl/zbt_sram_chk.sv
module zbt_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cke_ni,
  input logic ld_ni,
  input logic oe_ni,
  input logic sel_ok,
  input logic burst_act,
  input logic s1_vld,
  input logic s1_wr,
  input logic drv_q,
  input logic drive_o
);

  // R10
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !drive_o);

  // R4
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !ld_ni && !sel_ok) |=> !s1_vld);

  // R9
  idle_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && ld_ni && !burst_act) |=> !s1_vld);

  // R5
  wr_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && s1_vld && s1_wr) |=> !drv_q);

  // R1
  rd_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && s1_vld && !s1_wr) |=> drv_q);

  // R3
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(drv_q) && $stable(s1_vld) && $stable(burst_act)));

endmodule

bind zbt_sram zbt_sram_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cke_ni   (cke_ni),
  .ld_ni    (ld_ni),
  .oe_ni    (oe_ni),
  .sel_ok   (sel_ok),
  .burst_act(burst_act),
  .s1_vld   (s1_vld),
  .s1_wr    (s1_wr),
  .drv_q    (drv_q),
  .drive_o  (drive_o)
);

// File: tb/zbt_sram_bench.sv
`timescale 1ns/1ps
module zbt_sram_bench;

  localparam int AW = 8;
  localparam int DW = 36;

  typedef struct packed {
    logic          sel;
    logic          ld_n;
    logic          wr;
    logic [3:0]    be;
    logic          lin;
    logic [AW-1:0] addr;
    logic [DW-1:0] dat;   // write data, or expected read word
    logic          drv;   // read data expected in this entry's data cycle
  } vec_t;

  localparam logic [DW-1:0] A0 = 36'h0A0A0A0A0, A1 = 36'h1A1A1A1A1;
  localparam logic [DW-1:0] B  = 36'h123456789, C  = 36'hFEDCBA987;
  localparam logic [DW-1:0] M  = 36'h007FC01FF;  // lanes 0 and 2
  localparam logic [DW-1:0] MG = (B & ~M) | (C & M);
  localparam logic [DW-1:0] D0 = 36'h0D0D0D0D0, D1 = 36'h1D1D1D1D1;
  localparam logic [DW-1:0] D2 = 36'h2D2D2D2D2, D3 = 36'h3D3D3D3D3;

  localparam int N = 27;
  localparam vec_t TBL [N] = '{
    '{1'b1, 1'b0, 1'b1, 4'hF, 1'b1, 8'h10, A0, 1'b0},   // R2 writes
    '{1'b1, 1'b0, 1'b1, 4'hF, 1'b1, 8'h11, A1, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h10, A0, 1'b1},   // R1
    '{1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h11, A1, 1'b1},
    '{1'b1, 1'b0, 1'b1, 4'hF, 1'b1, 8'h20, B,  1'b0},
    '{1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h20, B,  1'b1},   // R2 bypass
    '{1'b1, 1'b0, 1'b1, 4'h5, 1'b1, 8'h20, C,  1'b0},   // R8 lanes 0,2
    '{1'b1, 1'b0, 1'b0, 4'h0, 1'b1, 8'h20, MG, 1'b1},
    '{1'b1, 1'b0, 1'b1, 4'hF, 1'b1, 8'h31, D1, 1'b0},   // R6 write burst
    '{1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, D2, 1'b0},   // R9 type kept
    '{1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, D3, 1'b0},
    '{1'b1, 1'b1, 1'b0, 4'h0, 1'b0, 8'h00, D0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h30, D0, 1'b1},   // R6 linear read
    '{1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 8'hFF, D1, 1'b1},
    '{1'b0, 1'b1, 1'b1, 4'hF, 1'b0, 8'hFF, D2, 1'b1},   // R6 cs ignored
    '{1'b1, 1'b1, 1'b1, 4'hF, 1'b0, 8'hFF, D3, 1'b1},
    '{1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 8'h32, D2, 1'b1},   // R7 start 2
    '{1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, D3, 1'b1},
    '{1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, D0, 1'b1},
    '{1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, D1, 1'b1},
    '{1'b1, 1'b0, 1'b0, 4'hF, 1'b0, 8'h31, D1, 1'b1},   // R7 start 1
    '{1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, D0, 1'b1},
    '{1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, D3, 1'b1},
    '{1'b1, 1'b1, 1'b0, 4'h0, 1'b1, 8'h00, D2, 1'b1},
    '{1'b0, 1'b0, 1'b0, 4'hF, 1'b1, 8'h10, '0, 1'b0},   // R4 deselect
    '{1'b1, 1'b1, 1'b0, 4'hF, 1'b1, 8'h10, '0, 1'b0},   // R9 no-op
    '{1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h10, A0, 1'b1}
  };

  logic          clk_i = 1'b0, rst_ni = 1'b0, cke_ni = 1'b0;
  logic          cs0_ni = 1'b1, cs1_i = 1'b0, cs2_ni = 1'b1;
  logic          ld_ni = 1'b0, wr_i = 1'b0, lin_i = 1'b1, oe_ni = 1'b0;
  logic [3:0]    bwe_i = '0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic          drive_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  zbt_sram u_zbt_sram (
    .clk_i, .rst_ni, .cke_ni, .cs0_ni, .cs1_i, .cs2_ni, .ld_ni, .wr_i,
    .bwe_i, .lin_i, .addr_i, .wdata_i, .oe_ni, .rdata_o, .drive_o
  );

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic set_cmd(input logic sel, input logic ld_n, input logic wr,
                         input logic [3:0] be, input logic lin,
                         input logic [AW-1:0] a);
    cs0_ni = !sel; cs1_i = sel; cs2_ni = !sel;
    ld_ni = ld_n; wr_i = wr; bwe_i = be; lin_i = lin; addr_i = a;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic nop();
    set_cmd(1'b0, 1'b0, 1'b0, 4'h0, 1'b1, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    nop();
    repeat (3) @(negedge clk_i);
    // R11 reset state
    check("R11 drive", {35'd0, drive_o}, '0);
    check("R11 rdata", rdata_o, '0);
    rst_ni = 1'b1;
    tick();
    // R9 advance with no burst since reset
    set_cmd(1'b1, 1'b1, 1'b0, 4'hF, 1'b1, 8'h10);
    tick();
    nop();
    tick();
    check("R9 adv after reset", {35'd0, drive_o}, '0);

    // table walk: command j, write data for j-2, check data cycle of j-1
    for (int j = 0; j <= N; j++) begin
      if (j < N) set_cmd(TBL[j].sel, TBL[j].ld_n, TBL[j].wr, TBL[j].be,
                         TBL[j].lin, TBL[j].addr);
      else nop();
      if (j >= 2) wdata_i = TBL[j-2].dat;
      tick();
      if (j >= 1) begin
        check($sformatf("R1 R5 drive vec %0d", j-1), {35'd0, drive_o},
              {35'd0, TBL[j-1].drv});
        check($sformatf("R2 R6 R7 R8 data vec %0d", j-1), rdata_o,
              TBL[j-1].drv ? TBL[j-1].dat : '0);
      end
    end
    nop();
    tick();

    // R4 each select alone blocks a load
    for (int k = 0; k < 3; k++) begin
      set_cmd(1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h10);
      if (k == 0) cs0_ni = 1'b1;
      if (k == 1) cs1_i  = 1'b0;
      if (k == 2) cs2_ni = 1'b1;
      tick();
      nop();
      tick();
      check($sformatf("R4 select %0d", k), {35'd0, drive_o}, '0);
    end

    // R3 freeze: read issued, then clock enable held off with a write
    set_cmd(1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h11);
    tick();
    cke_ni = 1'b1;
    set_cmd(1'b1, 1'b0, 1'b1, 4'hF, 1'b1, 8'h11);
    wdata_i = 36'h555555555;
    for (int f = 0; f < 3; f++) begin
      tick();
      check("R3 frozen drive", {35'd0, drive_o}, '0);
    end
    cke_ni = 1'b0;
    nop();
    tick();
    check("R3 resumed drive", {35'd0, drive_o}, 36'd1);
    check("R3 resumed data", rdata_o, A1);
    tick();
    set_cmd(1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h11);
    tick();
    nop();
    tick();
    check("R3 no frozen write", rdata_o, A1);

    // R10 asynchronous output enable
    set_cmd(1'b1, 1'b0, 1'b0, 4'hF, 1'b1, 8'h20);
    tick();
    nop();
    tick();
    oe_ni = 1'b1;
    #0.5;
    check("R10 drive off", {35'd0, drive_o}, '0);
    check("R10 data off", rdata_o, '0);
    oe_ni = 1'b0;
    #0.5;
    check("R10 drive back", {35'd0, drive_o}, 36'd1);
    check("R10 data back", rdata_o, MG);
    tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule